// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a synchronous single-port memory that keeps its data bus fully used. Reads and writes may follow each other in any mix, with no idle cycle between them. A read is flow-through: its data is driven in the clock period right after the edge that captures the address. A write is a late write: its data is taken from the bus at the next enabled clock edge after its address. The bidirectional bus is modelled by a separate data input, a data output and an output-drive flag.

One captured address opens a burst. While the load/advance control stays high, a two-bit beat counter steps through four word addresses within an aligned group of four, in either wrapping linear order or interleaved (XOR) order. The order is chosen by a select input sampled when the address is loaded. A clock enable freezes the whole block. Three chip selects with mixed polarity can deselect it. A write that is already waiting for its data still completes on the deselect edge. An asynchronous output enable can silence the bus at any time.

Top module: `nolat_burst_sram`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its pending operation, and `dq_oe` is low after that edge.
- R2: A load (`adv_ld` low, selected, `we_n` high) captured at edge k drives `dq_out` with the word at `addr` and raises `dq_oe` between edge k and edge k+1, unless `oe_n` is high.
- R3: For a write captured at edge k, `dq_in` is sampled at the next enabled edge. Only lanes whose `lane_n` bit (sampled at edge k) is low are updated, and bit i covers `dq_in[8i+7:8i]`.
- R4: With `adv_ld` high after a selected load with `order_il` low, beat n (0 to 3, wrapping after 3) addresses the word whose two low bits are (base + n) mod 4. The upper bits do not change.
- R5: With `order_il` high at the load, beat n addresses the word whose two low bits are base XOR n.
- R6: When `cke_n` is high at an edge, every input is ignored. No lane is written, the burst position stays as it was, and `dq_out` and `dq_oe` stay unchanged.
- R7: A load edge with `cs1_n` high, `cs2` low or `cs3_n` high starts nothing and ends any burst, so `dq_oe` is low after it and later advances drive nothing. A write pending at that edge still takes its data.
- R8: `oe_n` high forces `dq_oe` low combinationally, whatever the internal state.
- R9: Operations may alternate in consecutive cycles. A read loaded at the edge that completes a write to the same address returns the newly written bytes.
- R10: During the period after a write beat is captured, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | Low: load new address and command; high: advance burst |
| we_n | input | 1 | Write when low at a load, read when high |
| lane_n | input | LANES | Per-byte write selects, active low |
| order_il | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus, zero when not driven |
| dq_oe | output | 1 | Bus drive flag |

## Verification
The assertions assume a synchronous reset is applied before any command. They also assume every control input is settled at the rising edge, with `oe_n` the only input allowed to change combinationally. The stimulus drives every input at the falling edge, so each input holds stable across the sampling edge. Reset is asserted for several cycles before any operation. Random traffic freely mixes freezes, deselects on each of the three selects, loads, advances and output-enable pulses. All of it stays within the assumption that the memory was first filled by write bursts, so no read returns an unwritten word.

// File: rtl/nlb_pkg.sv
`timescale 1ns/1ps
package nlb_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef struct packed {
        logic       valid;
        op_e        op;
        logic       il;
        logic [1:0] cnt;
    } burst_st_t;

    function automatic logic [1:0] beat_lsb(input logic [1:0] base,
                                            input logic [1:0] n,
                                            input logic       il);
        return il ? (base ^ n) : (base + n);
    endfunction

endpackage

// File: rtl/nlb_burst_ctl.sv
`timescale 1ns/1ps
module nlb_burst_ctl
    import nlb_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_n,
    input  logic             sel,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             order_il,
    input  logic [AW-1:0]    addr,
    output burst_st_t        st,
    output logic [AW-1:0]    cur_addr,
    output logic [LANES-1:0] cur_lane_n
);

    burst_st_t        st_q;
    logic [AW-1:0]    base_q;
    logic [LANES-1:0] lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            base_q <= '0;
            lane_q <= '1;
        end else if (!cke_n) begin
            lane_q <= lane_n;
            if (!adv_ld) begin
                if (sel) begin
                    st_q.valid <= 1'b1;
                    st_q.op    <= we_n ? OP_RD : OP_WR;
                    st_q.il    <= order_il;
                    st_q.cnt   <= 2'd0;
                    base_q     <= addr;
                end else begin
                    st_q.valid <= 1'b0;
                end
            end else if (st_q.valid) begin
                st_q.cnt <= st_q.cnt + 2'd1;
            end
        end
    end

    assign st         = st_q;
    assign cur_lane_n = lane_q;
    assign cur_addr   = {base_q[AW-1:2], beat_lsb(base_q[1:0], st_q.cnt, st_q.il)};

endmodule

// File: rtl/nlb_lane_array.sv
`timescale 1ns/1ps
module nlb_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/nolat_burst_sram.sv
`timescale 1ns/1ps
module nolat_burst_sram
    import nlb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    order_il,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic             sel;
    burst_st_t        st;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0] cur_lane_n;
    logic             wr_go;
    logic [LANES-1:0] lane_we;
    logic [DATA_W-1:0] rdata;
    logic             drive;

    assign sel = !cs1_n && cs2 && !cs3_n;

    nlb_burst_ctl #(
        .AW    (ADDR_W),
        .LANES (LANES)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cke_n      (cke_n),
        .sel        (sel),
        .adv_ld     (adv_ld),
        .we_n       (we_n),
        .lane_n     (lane_n),
        .order_il   (order_il),
        .addr       (addr),
        .st         (st),
        .cur_addr   (cur_addr),
        .cur_lane_n (cur_lane_n)
    );

    assign wr_go   = !rst && !cke_n && st.valid && (st.op == OP_WR);
    assign lane_we = wr_go ? ~cur_lane_n : '0;

    nlb_lane_array #(
        .AW     (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (cur_addr),
        .wdata   (dq_in),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );

    assign drive  = st.valid && (st.op == OP_RD) && !oe_n;
    assign dq_oe  = drive;
    assign dq_out = drive ? rdata : '0;

endmodule

// File: rtl/nlb_sram_chk.sv
`timescale 1ns/1ps
module nlb_sram_chk
    import nlb_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cke_n,
    input logic          adv_ld,
    input logic          sel,
    input logic          oe_n,
    input logic          dq_oe,
    input burst_st_t     st,
    input logic [AW-1:0] cur_addr
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dq_oe); // R1

    AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe); // R8

    AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st.valid && st.op == OP_WR) |-> !dq_oe); // R10

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(st) && $stable(cur_addr))); // R6

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !adv_ld && !sel) |=> (!st.valid && !dq_oe)); // R7

    AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && adv_ld && st.valid) |=>
        (st.valid && st.cnt == $past(st.cnt) + 2'd1 && st.op == $past(st.op))); // R4

endmodule

bind nolat_burst_sram nlb_sram_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cke_n    (cke_n),
    .adv_ld   (adv_ld),
    .sel      (sel),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .st       (st),
    .cur_addr (cur_addr)
);

// File: tb/tb_nolat_burst_sram.sv
`timescale 1ns/1ps
module tb_nolat_burst_sram;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 8;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, cke_n, cs1_n, cs2, cs3_n, adv_ld, we_n, order_il, oe_n;
    logic [LANES-1:0] lane_n;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    dq_in, dq_out;
    logic             dq_oe;

    nolat_burst_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) dut (
        .clk(clk), .rst(rst), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .adv_ld(adv_ld), .we_n(we_n), .lane_n(lane_n),
        .order_il(order_il), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // bench model
    logic          m_valid, m_wr, m_il;
    logic [1:0]    m_cnt;
    logic [AW-1:0] m_base;
    logic [LANES-1:0] m_lane;
    logic [DW-1:0] ref_mem [DEPTH];

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic sel;
        if (rst) begin
            m_valid = 0; m_wr = 0; m_il = 0; m_cnt = 0; m_base = '0; m_lane = '1;
            return;
        end
        if (cke_n) return;
        if (m_valid && m_wr) begin
            for (int i = 0; i < LANES; i++)
                if (!m_lane[i]) ref_mem[m_addr()][i*LW +: LW] = dq_in[i*LW +: LW];
        end
        sel = !cs1_n && cs2 && !cs3_n;
        m_lane = lane_n;
        if (!adv_ld) begin
            if (sel) begin
                m_valid = 1; m_wr = !we_n; m_il = order_il; m_cnt = 0; m_base = addr;
            end else begin
                m_valid = 0;
            end
        end else if (m_valid) begin
            m_cnt = m_cnt + 2'd1;
        end
    endtask

    task automatic verify(input string tag_in);
        string tag;
        logic  exp_oe;
        tag = tag_in;
        if (tag == "") begin
            if (oe_n) tag = "R8";
            else if (!m_valid) tag = "R7";
            else if (m_wr) tag = "R10";
            else if (m_cnt != 0) tag = m_il ? "R5" : "R4";
            else tag = "R2";
        end
        exp_oe = m_valid && !m_wr && !oe_n;
        check(tag, "dq_oe", {{(DW-1){1'b0}}, dq_oe}, {{(DW-1){1'b0}}, exp_oe});
        if (exp_oe) check(tag, "dq_out", dq_out, ref_mem[m_addr()]);
    endtask

    // inputs are set at the falling edge before calling step
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        verify(tag);
    endtask

    task automatic set_in(input logic ckn, input logic ld, input logic wr,
                          input logic [AW-1:0] a, input logic [LANES-1:0] ln,
                          input logic il, input logic [DW-1:0] d);
        cke_n = ckn; cs1_n = 0; cs2 = 1; cs3_n = 0;
        adv_ld = !ld; we_n = !wr; addr = a; lane_n = ln; order_il = il;
        dq_in = d; oe_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1;
        set_in(0, 0, 0, '0, '1, 0, '0);
        cs2 = 0;
        repeat (3) @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R1", "dq_oe after reset", {{(DW-1){1'b0}}, dq_oe}, '0);
        rst = 0;

        // fill memory with write bursts (R3)
        for (int b = 0; b < DEPTH / 4; b++) begin
            set_in(0, 1, 1, AW'(b * 4), '0, 0, $urandom);
            step("R3");
            for (int k = 0; k < 3; k++) begin
                set_in(0, 0, 1, '0, '0, 0, $urandom);
                step("R3");
            end
        end
        set_in(0, 1, 0, '0, '1, 0, $urandom);
        cs3_n = 1;
        step("R7");

        // R9: write then immediate read of same address, then read->write->read
        set_in(0, 1, 1, 6'd5, '0, 0, '0);           step("R9");
        set_in(0, 1, 0, 6'd5, '1, 0, 32'hA5A51234); step("R9");
        check("R9", "read after write", dq_out, 32'hA5A51234);
        set_in(0, 1, 1, 6'd6, '0, 0, '0);           step("R9");
        set_in(0, 1, 0, 6'd6, '1, 0, 32'h0BADF00D); step("R9");
        check("R9", "read->write->read", dq_out, 32'h0BADF00D);

        // R3: partial lane write
        set_in(0, 1, 1, 6'd9, 4'b0000, 0, '0);          step("R3");
        set_in(0, 1, 1, 6'd9, 4'b1010, 0, 32'h11223344); step("R3");
        set_in(0, 1, 0, 6'd9, '1, 0, 32'hAABBCCDD);      step("R3");
        check("R3", "lane merge", dq_out, 32'h11BB33DD);

        // R6: freeze during a read and during a pending write
        set_in(0, 1, 0, 6'd12, '1, 0, '0); step("R2");
        for (int k = 0; k < 3; k++) begin
            set_in(1, k[0], 1, 6'd40, '0, 1, $urandom);
            step("R6");
            check("R6", "held read", dq_out, ref_mem[12]);
        end
        set_in(0, 1, 1, 6'd20, '0, 0, '0);          step("R6");
        set_in(1, 1, 0, 6'd20, '0, 0, 32'hDEAD0001); step("R6");
        set_in(0, 1, 0, 6'd20, '1, 0, 32'h600D0002); step("R6");
        check("R6", "write after freeze", dq_out, 32'h600D0002);

        // R7: deselect completes pending write, later advance idle
        set_in(0, 1, 1, 6'd30, '0, 0, '0);          step("R7");
        set_in(0, 1, 0, 6'd33, '1, 0, 32'hC0FFEE77);
        cs2 = 0;                                    step("R7");
        set_in(0, 0, 0, 6'd0, '1, 0, '0);           step("R7");
        check("R7", "advance after deselect", {{(DW-1){1'b0}}, dq_oe}, '0);
        set_in(0, 1, 0, 6'd30, '1, 0, '0);          step("R7");
        check("R7", "pending write kept", dq_out, 32'hC0FFEE77);

        // R4 linear from base 2, R5 interleaved from base 1
        set_in(0, 1, 0, 6'd18, '1, 0, '0); step("R2");
        for (int k = 0; k < 5; k++) begin
            set_in(0, 0, 0, '0, '1, 0, '0); step("R4");
        end
        set_in(0, 1, 0, 6'd45, '1, 1, '0); step("R2");
        for (int k = 0; k < 5; k++) begin
            set_in(0, 0, 0, '0, '1, 1, '0); step("R5");
        end

        // R8: output enable off during read
        set_in(0, 1, 0, 6'd3, '1, 0, '0); oe_n = 1; step("R8");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            set_in(($urandom % 8) == 0, ($urandom % 3) == 0, $urandom % 2,
                   AW'($urandom), LANES'($urandom), $urandom % 2, $urandom);
            if (($urandom % 8) == 0) begin
                case ($urandom % 3)
                    0: cs1_n = 1;
                    1: cs2   = 0;
                    default: cs3_n = 1;
                endcase
            end
            oe_n = ($urandom % 10) == 0;
            step("");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule